// File: doc/BRIEF.md
# Match timer with watchdog reset

This block is a register-mapped operating-system timer. A 32-bit up-counter advances by one on every cycle where an external tick strobe is high. It wraps modulo 2^32 and software may reload it at any time. Four 32-bit compare registers are checked for exact equality against the counter, but only when the counter takes a new value. A hit on a channel whose interrupt enable bit is set latches a sticky status bit, and that status bit drives the channel's interrupt line. Software clears a status bit by writing a one to it.

Compare channel 3 also serves as a one-shot watchdog. If its arm bit is set when channel 3 hits, the block emits a one-cycle system reset request and clears the arm bit. Software uses it by arming the watchdog and then pushing the channel 3 compare value ahead of the counter before the counter reaches it. The tick source sets the count rate. Nominal rates are 3.6864 MHz or 3.25 MHz, depending on the device variant, and they are produced outside this block.

The register bus is a single-cycle request (valid, write, address, write data). Read data and the error flag are registered and appear on the clock after the request.

Top module: `os_match_timer`

## Requirements
- R1: After reset the counter, all compare registers, the interrupt enable register, the watchdog arm register and the status register read zero, and irq and reset_req are low.
- R2: The counter (offset 0x10) increases by exactly one on each cycle with tick_en high and holds otherwise. 0xFFFFFFFF steps to 0x00000000.
- R3: A write to offset 0x10 loads the counter and takes priority over a tick in the same cycle. Later ticks count on from the loaded value.
- R4: Compare register n sits at offset 4*n (0x00, 0x04, 0x08, 0x0C) and reads back what was written.
- R5: When the counter takes a value equal to compare register n and interrupt enable bit n is set, status bit n (offset 0x14, bit n) and irq[n] go high on that same clock edge. A hit neither stops nor reloads the counter, and this includes a hit at the wrap to zero.
- R6: A hit on a channel whose interrupt enable bit is clear leaves its status bit and irq line low.
- R7: Writing status with bit n set clears status bit n and lowers irq[n]. Writing 0, or writing 1 to a bit that is not set, changes nothing. A new hit in the same cycle as a clear leaves the bit set.
- R8: The interrupt enable register (offset 0x1C) stores bits [11:0] only. Higher bits read as zero. Bit n enables channel n.
- R9: The watchdog arm register (offset 0x18) stores bit 0 only. A channel 3 hit while it is 1 pulses reset_req high for exactly one cycle on that edge and clears the arm bit. This does not depend on the interrupt enable bit. A channel 3 hit while it is 0 gives no request.
- R10: Read data and bus_err appear on the clock after a read request. A read from any other offset than those above returns zero with bus_err high for one cycle. A write to such an offset changes nothing.
- R11: Writing a compare register with the value the counter already holds causes no hit, because the comparison happens only when the counter changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe, one step per high cycle |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle flag for a read of an unmapped offset |
| irq | output | 4 | Per-channel interrupt lines, mirror of the status bits |
| reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
The compare function is driven with plain ticking up to a compare value, with a count that crosses a value whose channel is disabled, with a hit at the wrap to zero, and with a compare register written to equal the idle counter. Together these separate "enabled hit" from "masked hit", and "counter changed" from "values merely equal". Status clearing is tried with zero, with ones on clear bits, with a real clear, and with a clear that collides with a fresh hit, which tells a true one-to-clear from a plain write. The watchdog is run armed, then disarmed and with interrupts off, so the reset pulse is seen to be one cycle wide, self-disarming and independent of the interrupt mask.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

  // Register byte offsets; compare channel n sits at CMP_BASE + 4*n
  localparam int unsigned CMP_BASE = 'h00;
  localparam int unsigned OFS_CNT  = 'h10;
  localparam int unsigned OFS_STAT = 'h14;
  localparam int unsigned OFS_ARM  = 'h18;
  localparam int unsigned OFS_IEN  = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMP,
    SEL_CNT,
    SEL_STAT,
    SEL_ARM,
    SEL_IEN
  } reg_sel_e;

endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         cnt_upd
);

  // a load wins over a tick; the sum wraps naturally at W bits
  always_comb begin
    cnt_upd = load_en | tick_en;
    cnt_nxt = load_en ? load_val : (cnt_q + W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_nxt;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_en) |=> $stable(cnt_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_en) |=> (cnt_q == $past(cnt_q) + W'(1))); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_q == $past(load_val))); // R3

endmodule

// File: rtl/ostmr_cmp_ch.sv
module ostmr_cmp_ch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] cnt_nxt,
  input  logic         cnt_upd,
  output logic [W-1:0] cmp_q,
  output logic         hit
);

  logic [W-1:0] cmp_d;

  always_comb begin
    cmp_d = wr_en ? wr_val : cmp_q;
    // compare against the value the counter is about to take
    hit   = cnt_upd && (cnt_nxt == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  AST_CMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cmp_q == $past(wr_val))); // R4

endmodule

// File: rtl/ostmr_event.sv
module ostmr_event #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IEN_W  = 12,
  parameter int unsigned WD_CH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit,
  input  logic              ien_wr,
  input  logic [IEN_W-1:0]  ien_wdata,
  input  logic              stat_wr,
  input  logic [NUM_CH-1:0] stat_wdata,
  input  logic              arm_wr,
  input  logic              arm_wdata,
  output logic [IEN_W-1:0]  ien_q,
  output logic [NUM_CH-1:0] stat_q,
  output logic              arm_q,
  output logic              reset_req
);

  logic [IEN_W-1:0]  ien_d;
  logic [NUM_CH-1:0] stat_d;
  logic              arm_d;
  logic              fire;

  always_comb begin
    ien_d = ien_wr ? ien_wdata : ien_q;
    for (int n = 0; n < NUM_CH; n++) begin
      // a fresh hit outranks a clear in the same cycle
      if (hit[n] && ien_q[n])            stat_d[n] = 1'b1;
      else if (stat_wr && stat_wdata[n]) stat_d[n] = 1'b0;
      else                               stat_d[n] = stat_q[n];
    end
    fire  = hit[WD_CH] & arm_q;
    arm_d = fire ? 1'b0 : (arm_wr ? arm_wdata : arm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q     <= '0;
      stat_q    <= '0;
      arm_q     <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      ien_q     <= ien_d;
      stat_q    <= stat_d;
      arm_q     <= arm_d;
      reset_req <= fire;
    end
  end

  AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R9
  AST_WDOG_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !arm_q); // R9

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_STAT_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[g]) |-> $past(ien_q[g])); // R6
    AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q[g]) |-> $past(stat_wr && stat_wdata[g])); // R7
  end

endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IEN_W  = 12,
  parameter int unsigned WD_CH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [NUM_CH-1:0] irq,
  output logic              reset_req
);
  import ostmr_pkg::*;

  localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  reg_sel_e            sel;
  logic [CH_IDX_W-1:0] cmp_idx;
  logic                wr_req;
  logic                rd_req;
  logic [NUM_CH-1:0]   cmp_wr;
  logic [NUM_CH-1:0]   hit;
  logic [DATA_W-1:0]   cmp_q [NUM_CH];
  logic [DATA_W-1:0]   cnt_q;
  logic [DATA_W-1:0]   cnt_nxt;
  logic                cnt_upd;
  logic [IEN_W-1:0]    ien_q;
  logic [NUM_CH-1:0]   stat_q;
  logic                arm_q;
  logic [DATA_W-1:0]   rd_val;
  logic [DATA_W-1:0]   rdata_d;
  logic                err_d;

  // address decode
  always_comb begin
    sel     = SEL_NONE;
    cmp_idx = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ADDR_W'(CMP_BASE + 4 * n)) begin
        sel     = SEL_CMP;
        cmp_idx = CH_IDX_W'(n);
      end
    end
    if (bus_addr == ADDR_W'(OFS_CNT))  sel = SEL_CNT;
    if (bus_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    if (bus_addr == ADDR_W'(OFS_ARM))  sel = SEL_ARM;
    if (bus_addr == ADDR_W'(OFS_IEN))  sel = SEL_IEN;
    wr_req = bus_valid &  bus_write;
    rd_req = bus_valid & ~bus_write;
    for (int n = 0; n < NUM_CH; n++)
      cmp_wr[n] = wr_req && (sel == SEL_CMP) && (cmp_idx == CH_IDX_W'(n));
  end

  ostmr_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load_en  (wr_req && (sel == SEL_CNT)),
    .load_val (bus_wdata),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .cnt_upd  (cnt_upd)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ostmr_cmp_ch #(.W(DATA_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cmp_wr[g]),
      .wr_val  (bus_wdata),
      .cnt_nxt (cnt_nxt),
      .cnt_upd (cnt_upd),
      .cmp_q   (cmp_q[g]),
      .hit     (hit[g])
    );
  end

  ostmr_event #(.NUM_CH(NUM_CH), .IEN_W(IEN_W), .WD_CH(WD_CH)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .ien_wr     (wr_req && (sel == SEL_IEN)),
    .ien_wdata  (bus_wdata[IEN_W-1:0]),
    .stat_wr    (wr_req && (sel == SEL_STAT)),
    .stat_wdata (bus_wdata[NUM_CH-1:0]),
    .arm_wr     (wr_req && (sel == SEL_ARM)),
    .arm_wdata  (bus_wdata[0]),
    .ien_q      (ien_q),
    .stat_q     (stat_q),
    .arm_q      (arm_q),
    .reset_req  (reset_req)
  );

  // read path
  always_comb begin
    unique case (sel)
      SEL_CMP:  rd_val = cmp_q[cmp_idx];
      SEL_CNT:  rd_val = cnt_q;
      SEL_STAT: rd_val = DATA_W'(stat_q);
      SEL_ARM:  rd_val = DATA_W'(arm_q);
      SEL_IEN:  rd_val = DATA_W'(ien_q);
      default:  rd_val = '0;
    endcase
    rdata_d = rd_req ? rd_val : '0;
    err_d   = rd_req && (sel == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= err_d;
    end
  end

  assign irq = stat_q;

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0)); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> !bus_err); // R10

endmodule

// File: tb/tb_os_match_timer.sv
module tb_os_match_timer;

  localparam logic [7:0] A_M0 = 8'h00, A_M1 = 8'h04, A_M2 = 8'h08, A_M3 = 8'h0C;
  localparam logic [7:0] A_CNT = 8'h10, A_ST = 8'h14, A_ARM = 8'h18, A_IEN = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_valid;
  logic        bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  irq;
  logic        reset_req;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  typedef struct {
    logic [31:0] exp;
    logic        err;
    string       tag;
    int          due;
  } rd_item_t;

  rd_item_t sb_q[$];

  os_match_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .irq       (irq),
    .reset_req (reset_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare read results in the cycle they are due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      rd_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp || bus_err !== it.err) begin
        errors++;
        $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                 it.tag, bus_rdata, bus_err, it.exp, it.err);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input logic er, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; tick_en = 1'b0;
    sb_q.push_back('{exp: e, err: er, tag: tag, due: cyc + 1});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 1'b0; tick_en = 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 1'b0; tick_en = 1'b0;
    end
  endtask

  task automatic pins(input logic [3:0] e_irq, input logic e_rr, input string tag);
    @(negedge clk);
    bus_valid = 1'b0; tick_en = 1'b0;
    checks++;
    if (irq !== e_irq || reset_req !== e_rr) begin
      errors++;
      $display("FAIL %s: irq=%b reset_req=%b expected irq=%b reset_req=%b",
               tag, irq, reset_req, e_irq, e_rr);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    pins(4'b0000, 1'b0, "R1 outputs after reset");
    rd(A_M0, 0, 0, "R1 cmp0"); rd(A_M3, 0, 0, "R1 cmp3");
    rd(A_CNT, 0, 0, "R1 counter"); rd(A_ST, 0, 0, "R1 status");
    rd(A_ARM, 0, 0, "R1 arm"); rd(A_IEN, 0, 0, "R1 ien");

    // R4 compare registers
    wr(A_M0, 32'h11, 0); wr(A_M1, 32'h22, 0); wr(A_M2, 32'h33, 0); wr(A_M3, 32'h44, 0);
    rd(A_M0, 32'h11, 0, "R4 cmp0"); rd(A_M1, 32'h22, 0, "R4 cmp1");
    rd(A_M2, 32'h33, 0, "R4 cmp2"); rd(A_M3, 32'h44, 0, "R4 cmp3");

    // R8 enable width
    wr(A_IEN, 32'hFFFF_FFFF, 0);
    rd(A_IEN, 32'h0000_0FFF, 0, "R8 upper bits dropped");
    wr(A_IEN, 32'h5, 0);

    // R3 / R2 load and count
    wr(A_CNT, 100, 0);
    rd(A_CNT, 100, 0, "R3 load");
    tick(5);
    rd(A_CNT, 105, 0, "R2 five ticks");
    idle(2);
    rd(A_CNT, 105, 0, "R2 hold without tick");

    // R5 / R6 enabled and masked hits
    wr(A_M0, 110, 0); wr(A_M1, 108, 0); wr(A_M2, 32'h200, 0); wr(A_M3, 32'h300, 0);
    tick(5);
    pins(4'b0001, 1'b0, "R5 irq0 on hit, R6 irq1 masked");
    rd(A_ST, 32'h1, 0, "R5/R6 status");
    tick(2);
    rd(A_CNT, 112, 0, "R5 counter keeps running");

    // R7 one-to-clear
    wr(A_ST, 32'h0, 0);
    rd(A_ST, 32'h1, 0, "R7 write zero");
    wr(A_ST, 32'hE, 0);
    rd(A_ST, 32'h1, 0, "R7 ones on clear bits");
    pins(4'b0001, 1'b0, "R7 irq kept");
    wr(A_ST, 32'h1, 0);
    rd(A_ST, 32'h0, 0, "R7 cleared");
    pins(4'b0000, 1'b0, "R7 irq lowered");

    // R11 equal value written while counter idle
    wr(A_M2, 112, 0);
    idle(2);
    rd(A_ST, 32'h0, 0, "R11 no hit without count change");
    tick(1);
    rd(A_ST, 32'h0, 0, "R11 counter moved past");

    // R2 wrap with hit at zero
    wr(A_M0, 0, 0);
    wr(A_CNT, 32'hFFFF_FFFE, 0);
    tick(2);
    rd(A_CNT, 0, 0, "R2 wrap to zero");
    rd(A_ST, 32'h1, 0, "R5 hit at wrap");
    wr(A_ST, 32'h1, 0);

    // R3 load beats tick
    wr(A_CNT, 50, 1);
    rd(A_CNT, 50, 0, "R3 load over tick");
    tick(3);
    rd(A_CNT, 53, 0, "R3 continue from load");

    // R9 watchdog
    wr(A_IEN, 0, 0);
    wr(A_M3, 60, 0);
    wr(A_ARM, 32'hFFFF_FFFF, 0);
    rd(A_ARM, 32'h1, 0, "R9 arm holds bit 0 only");
    wr(A_CNT, 59, 0);
    tick(1);
    pins(4'b0000, 1'b1, "R9 reset request on hit");
    pins(4'b0000, 1'b0, "R9 request one cycle");
    rd(A_ARM, 32'h0, 0, "R9 arm self-cleared");
    rd(A_ST, 32'h0, 0, "R6 ch3 masked");
    wr(A_CNT, 59, 0);
    tick(1);
    pins(4'b0000, 1'b0, "R9 disarmed no request");

    // R7 hit and clear collide
    wr(A_IEN, 32'h1, 0);
    wr(A_M0, 70, 0);
    wr(A_CNT, 69, 0);
    wr(A_ST, 32'h1, 1);
    rd(A_ST, 32'h1, 0, "R7 hit beats clear");
    pins(4'b0001, 1'b0, "R7 irq after collision");
    wr(A_ST, 32'h1, 0);
    rd(A_ST, 32'h0, 0, "R7 clear after collision");

    // R10 unmapped
    rd(8'h24, 0, 1, "R10 unmapped 0x24");
    rd(8'h11, 0, 1, "R10 unaligned 0x11");
    wr(8'h30, 32'hDEAD_BEEF, 0);
    rd(A_CNT, 70, 0, "R10 unmapped write ignored");
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule